// File: doc/BRIEF.md
# Flash Program and Mass-Erase Sequencer

This block sits between a small register bus and an externally powered flash array. Software drives it by writing one control byte and by writing into the flash address window. The block admits only the step sequence that the array tolerates: arm a mode, latch a target with one window write, raise high voltage, then do the byte writes or the erase. After that, high voltage is dropped in the proper order and the block waits a recovery time. Each analog wait is modelled as a parameterised cycle count. The count does not drive the array. It only decides when the next step becomes legal.

Any out-of-order or premature step is refused and raises a sticky sequence-error flag. A refused step leaves the array strobes untouched. In program mode every byte write must fall inside the 64-byte row that the latch write selected. A security input blocks program mode. Mass erase stays available. A busy output covers the whole interval from the latch write to the end of recovery, so the read path can stall flash fetches during that time.

Top module: `flash_seq_ctrl`

## Requirements
- R1: After reset the control byte (address 0) and the status byte (address 1) read 0x00, and arr_hv, arr_prog, arr_erase, arr_latch and rd_busy are low.
- R2: The control byte reads back program mode at bit 0, mass-erase mode at bit 2 and high voltage at bit 3. Bits 7:4 and bit 1 always read 0. The status byte has the sequence-error flag at bit 0 and the busy flag at bit 1. A read returns the value one clock after the address is presented.
- R3: Program mode and mass-erase mode are never both set. The block rejects a write that sets both, or that sets one while the other is set. A rejected write sets the error flag and leaves the control byte unchanged.
- R4: High voltage (0x09 or 0x0C) is accepted only after the mode is armed, a latch write has been made, and T_NVS cycles have passed. An earlier attempt is rejected with the error flag set.
- R5: In an armed mode, the first window write pulses arr_latch for one cycle with that address and data, and it raises rd_busy.
- R6: Under program high voltage, a byte write is accepted only after T_PGS has elapsed and no earlier byte is still running. An accepted byte pulses arr_latch and holds arr_prog high for exactly T_PROG cycles. An earlier write is rejected with no strobe.
- R7: During a program sequence, a byte write whose address bits above bit 5 differ from those of the latch write is rejected with no strobe. Any byte inside the 64-byte aligned row is accepted.
- R8: Leaving program mode takes two steps. First 0x08 is written, which needs no byte running and needs T_PGS elapsed. Then 0x00 is written, which is accepted only T_NVH cycles later. An earlier 0x00 write leaves the control byte at 0x08.
- R9: Under erase high voltage, arr_erase is high. Clearing erase mode (writing 0x08) is accepted only after T_ME cycles. After that, 0x00 is accepted T_NVH1 cycles later.
- R10: After high voltage is cleared, rd_busy stays high for T_RCV more cycles and then drops. A control write that sets any bit during this time is rejected.
- R11: While secure is high, the program bit of a control write is replaced by its current value, so program mode cannot be entered or left. No error is raised for this.
- R12: Writing 0x00 to the control byte always clears the error flag. If 0x00 is not a legal step, that write has no other effect. A rejected window write causes no arr_latch pulse, and a rejected control write does not change arr_hv, arr_prog or arr_erase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe (control byte only) |
| reg_addr | input | RA_W | Register address: 0 control, 1 status |
| reg_wdata | input | 8 | Register write data |
| rd_data | output | 8 | Registered read data for reg_addr |
| fw_wr | input | 1 | Flash-window write strobe |
| fw_addr | input | AW | Flash-window byte address |
| fw_data | input | 8 | Flash-window write data |
| secure | input | 1 | Security engaged; blocks the program bit |
| arr_latch | output | 1 | One-cycle strobe: latch arr_addr/arr_data into the array |
| arr_addr | output | AW | Latched address |
| arr_data | output | 8 | Latched data |
| arr_hv | output | 1 | High-voltage enable to the array |
| arr_prog | output | 1 | Program pulse |
| arr_erase | output | 1 | Mass-erase pulse |
| rd_busy | output | 1 | Array not readable |
| seq_err | output | 1 | Sticky sequence-error flag |

## Verification
If the phase register holds a wrong value, the fault shows on the next register read of the control byte. It also shows at the very next high-voltage or erase output, because those outputs follow the phase with one register of delay. If the wait counter is loaded or decremented wrongly, a step that should still be refused gets accepted, or the reverse. The bench probes this by making each step once too early and once after the wait. The result is visible in the control byte and the error bit two cycles later. A faulty row comparison or latch path shows as an extra, missing or wrong arr_latch pulse. The scoreboard catches this in the cycle the pulse appears.

// File: rtl/fpsq_pkg.sv
package fpsq_pkg;

  localparam int BIT_PGM = 0;
  localparam int BIT_ME  = 2;
  localparam int BIT_HV  = 3;

  localparam logic [7:0] CTRL_MASK = 8'h0D;
  localparam logic [7:0] C_NONE    = 8'h00;
  localparam logic [7:0] C_PGM     = 8'h01;
  localparam logic [7:0] C_ME      = 8'h04;
  localparam logic [7:0] C_HV      = 8'h08;
  localparam logic [7:0] C_PGM_HV  = 8'h09;
  localparam logic [7:0] C_ME_HV   = 8'h0C;

  typedef enum logic [3:0] {
    S_IDLE, S_P_ARM, S_P_LAT, S_P_HV, S_P_NVH,
    S_E_ARM, S_E_LAT, S_E_HV, S_E_NVH, S_RCV
  } fpsq_state_e;

  function automatic logic [7:0] ctrl_of(fpsq_state_e s);
    case (s)
      S_P_ARM, S_P_LAT: ctrl_of = C_PGM;
      S_P_HV:           ctrl_of = C_PGM_HV;
      S_E_ARM, S_E_LAT: ctrl_of = C_ME;
      S_E_HV:           ctrl_of = C_ME_HV;
      S_P_NVH, S_E_NVH: ctrl_of = C_HV;
      default:          ctrl_of = C_NONE;
    endcase
  endfunction

  function automatic logic is_busy(fpsq_state_e s);
    is_busy = (s == S_P_LAT) || (s == S_P_HV) || (s == S_P_NVH) ||
              (s == S_E_LAT) || (s == S_E_HV) || (s == S_E_NVH) ||
              (s == S_RCV);
  endfunction

endpackage

// File: rtl/fpsq_wait_timer.sv
module fpsq_wait_timer #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             done,
  output logic             last
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)               cnt_q <= '0;
    else if (load)         cnt_q <= load_val;
    else if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
  end

  assign done = (cnt_q == '0);
  assign last = (cnt_q == {{(CNT_W-1){1'b0}}, 1'b1});

  a_r4_timer_counts_down: assert property (@(posedge clk) disable iff (rst)
    (!load && !done) |=> (cnt_q == $past(cnt_q) - 1'b1));
endmodule

// File: rtl/fpsq_row_guard.sv
module fpsq_row_guard #(
  parameter int AW     = 11,
  parameter int ROW_LG = 6
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               capture,
  input  logic [AW-1:ROW_LG] row_in,
  output logic [AW-1:ROW_LG] row_q,
  output logic               row_hit
);
  always_ff @(posedge clk) begin
    if (rst)          row_q <= '0;
    else if (capture) row_q <= row_in;
  end

  assign row_hit = (row_in == row_q);
endmodule

// File: rtl/fpsq_seq_fsm.sv
module fpsq_seq_fsm
  import fpsq_pkg::*;
#(
  parameter int AW     = 11,
  parameter int CNT_W  = 16,
  parameter int T_NVS  = 4,
  parameter int T_PGS  = 12,
  parameter int T_PROG = 6,
  parameter int T_NVH  = 3,
  parameter int T_ME   = 20,
  parameter int T_NVH1 = 4,
  parameter int T_RCV  = 7
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ctrl_wr,
  input  logic [7:0]       ctrl_wdata,
  input  logic             fw_wr,
  input  logic [AW-1:0]    fw_addr,
  input  logic [7:0]       fw_data,
  input  logic             secure,
  input  logic             tmr_done,
  input  logic             tmr_last,
  input  logic             row_hit,
  output fpsq_state_e      state_q,
  output logic             tmr_load,
  output logic [CNT_W-1:0] tmr_val,
  output logic             row_cap,
  output logic             arr_latch,
  output logic [AW-1:0]    arr_addr,
  output logic [7:0]       arr_data,
  output logic             arr_hv,
  output logic             arr_prog,
  output logic             arr_erase,
  output logic             rd_busy,
  output logic             seq_err
);
  localparam logic [CNT_W-1:0] W_NVS  = CNT_W'(T_NVS);
  localparam logic [CNT_W-1:0] W_PGS  = CNT_W'(T_PGS);
  localparam logic [CNT_W-1:0] W_PROG = CNT_W'(T_PROG);
  localparam logic [CNT_W-1:0] W_NVH  = CNT_W'(T_NVH);
  localparam logic [CNT_W-1:0] W_ME   = CNT_W'(T_ME);
  localparam logic [CNT_W-1:0] W_NVH1 = CNT_W'(T_NVH1);
  localparam logic [CNT_W-1:0] W_RCV  = CNT_W'(T_RCV);

  fpsq_state_e nxt;
  logic [7:0]  cur, v;
  logic        zero_w, err_set, latch_go, prog_go, prog_on;

  always_comb begin
    cur = ctrl_of(state_q);
    v   = ctrl_wdata & CTRL_MASK;
    if (secure) v[BIT_PGM] = cur[BIT_PGM];
    zero_w   = ctrl_wr && (ctrl_wdata == 8'h00);
    nxt      = state_q;
    err_set  = 1'b0;
    latch_go = 1'b0;
    prog_go  = 1'b0;
    row_cap  = 1'b0;
    tmr_load = 1'b0;
    tmr_val  = '0;
    if (ctrl_wr) begin
      if (v != cur) begin
        err_set = 1'b1;
        case (state_q)
          S_IDLE:
            if (v == C_PGM)     begin nxt = S_P_ARM; err_set = 1'b0; end
            else if (v == C_ME) begin nxt = S_E_ARM; err_set = 1'b0; end
          S_P_ARM, S_E_ARM:
            if (v == C_NONE) begin nxt = S_IDLE; err_set = 1'b0; end
          S_P_LAT, S_E_LAT:
            if (v == C_NONE) begin
              nxt = S_RCV; tmr_load = 1'b1; tmr_val = W_RCV; err_set = 1'b0;
            end else if (tmr_done && state_q == S_P_LAT && v == C_PGM_HV) begin
              nxt = S_P_HV; tmr_load = 1'b1; tmr_val = W_PGS; err_set = 1'b0;
            end else if (tmr_done && state_q == S_E_LAT && v == C_ME_HV) begin
              nxt = S_E_HV; tmr_load = 1'b1; tmr_val = W_ME; err_set = 1'b0;
            end
          S_P_HV:
            if (v == C_HV && tmr_done && !prog_on) begin
              nxt = S_P_NVH; tmr_load = 1'b1; tmr_val = W_NVH; err_set = 1'b0;
            end
          S_E_HV:
            if (v == C_HV && tmr_done) begin
              nxt = S_E_NVH; tmr_load = 1'b1; tmr_val = W_NVH1; err_set = 1'b0;
            end
          S_P_NVH, S_E_NVH:
            if (v == C_NONE && tmr_done) begin
              nxt = S_RCV; tmr_load = 1'b1; tmr_val = W_RCV; err_set = 1'b0;
            end
          default: ;
        endcase
        if (zero_w) err_set = 1'b0;
      end
    end else if (fw_wr) begin
      case (state_q)
        S_P_ARM, S_E_ARM: begin
          nxt = (state_q == S_P_ARM) ? S_P_LAT : S_E_LAT;
          latch_go = 1'b1; row_cap = 1'b1;
          tmr_load = 1'b1; tmr_val = W_NVS;
        end
        S_P_HV:
          if (tmr_done && !prog_on && row_hit) begin
            latch_go = 1'b1; prog_go = 1'b1;
            tmr_load = 1'b1; tmr_val = W_PROG;
          end else err_set = 1'b1;
        default: err_set = 1'b1;
      endcase
    end else if (state_q == S_RCV && tmr_done) begin
      nxt = S_IDLE;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= S_IDLE;
      seq_err   <= 1'b0;
      prog_on   <= 1'b0;
      arr_latch <= 1'b0;
      arr_addr  <= '0;
      arr_data  <= '0;
      arr_hv    <= 1'b0;
      arr_erase <= 1'b0;
      rd_busy   <= 1'b0;
    end else begin
      state_q   <= nxt;
      if (zero_w)       seq_err <= 1'b0;
      else if (err_set) seq_err <= 1'b1;
      if (prog_go)       prog_on <= 1'b1;
      else if (tmr_last) prog_on <= 1'b0;
      arr_latch <= latch_go;
      if (latch_go) begin
        arr_addr <= fw_addr;
        arr_data <= fw_data;
      end
      arr_hv    <= ctrl_of(nxt)[BIT_HV];
      arr_erase <= (nxt == S_E_HV);
      rd_busy   <= is_busy(nxt);
    end
  end

  assign arr_prog = prog_on;

  a_r4_hv_after_latch: assert property (@(posedge clk) disable iff (rst)
    $rose(arr_hv) |-> ($past(state_q) == S_P_LAT || $past(state_q) == S_E_LAT));
  a_r6_prog_under_hv: assert property (@(posedge clk) disable iff (rst)
    arr_prog |-> arr_hv);
  a_r9_erase_under_hv: assert property (@(posedge clk) disable iff (rst)
    arr_erase |-> arr_hv);
  a_r3_modes_exclusive: assert property (@(posedge clk) disable iff (rst)
    !(arr_prog && arr_erase));
  a_r10_busy_covers_hv: assert property (@(posedge clk) disable iff (rst)
    arr_hv |-> rd_busy);
  a_r12_err_no_strobe: assert property (@(posedge clk) disable iff (rst)
    (fw_wr && !ctrl_wr && err_set) |=> !arr_latch);
endmodule

// File: rtl/flash_seq_ctrl.sv
module flash_seq_ctrl
  import fpsq_pkg::*;
#(
  parameter int AW     = 11,
  parameter int RA_W   = 2,
  parameter int ROW_LG = 6,
  parameter int CNT_W  = 16,
  parameter int T_NVS  = 4,
  parameter int T_PGS  = 12,
  parameter int T_PROG = 6,
  parameter int T_NVH  = 3,
  parameter int T_ME   = 20,
  parameter int T_NVH1 = 4,
  parameter int T_RCV  = 7
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            reg_wr,
  input  logic [RA_W-1:0] reg_addr,
  input  logic [7:0]      reg_wdata,
  output logic [7:0]      rd_data,
  input  logic            fw_wr,
  input  logic [AW-1:0]   fw_addr,
  input  logic [7:0]      fw_data,
  input  logic            secure,
  output logic            arr_latch,
  output logic [AW-1:0]   arr_addr,
  output logic [7:0]      arr_data,
  output logic            arr_hv,
  output logic            arr_prog,
  output logic            arr_erase,
  output logic            rd_busy,
  output logic            seq_err
);
  localparam logic [RA_W-1:0] A_CTRL = RA_W'(0);
  localparam logic [RA_W-1:0] A_STAT = RA_W'(1);

  fpsq_state_e      state;
  logic             ctrl_wr, tmr_load, tmr_done, tmr_last, row_cap, row_hit;
  logic [CNT_W-1:0] tmr_val;
  logic [AW-1:ROW_LG] row_q;

  assign ctrl_wr = reg_wr && (reg_addr == A_CTRL);

  fpsq_wait_timer #(.CNT_W(CNT_W)) u_tmr (
    .clk(clk), .rst(rst), .load(tmr_load), .load_val(tmr_val),
    .done(tmr_done), .last(tmr_last)
  );

  fpsq_row_guard #(.AW(AW), .ROW_LG(ROW_LG)) u_row (
    .clk(clk), .rst(rst), .capture(row_cap), .row_in(fw_addr[AW-1:ROW_LG]),
    .row_q(row_q), .row_hit(row_hit)
  );

  fpsq_seq_fsm #(
    .AW(AW), .CNT_W(CNT_W), .T_NVS(T_NVS), .T_PGS(T_PGS), .T_PROG(T_PROG),
    .T_NVH(T_NVH), .T_ME(T_ME), .T_NVH1(T_NVH1), .T_RCV(T_RCV)
  ) u_fsm (
    .clk(clk), .rst(rst), .ctrl_wr(ctrl_wr), .ctrl_wdata(reg_wdata),
    .fw_wr(fw_wr), .fw_addr(fw_addr), .fw_data(fw_data), .secure(secure),
    .tmr_done(tmr_done), .tmr_last(tmr_last), .row_hit(row_hit),
    .state_q(state), .tmr_load(tmr_load), .tmr_val(tmr_val), .row_cap(row_cap),
    .arr_latch(arr_latch), .arr_addr(arr_addr), .arr_data(arr_data),
    .arr_hv(arr_hv), .arr_prog(arr_prog), .arr_erase(arr_erase),
    .rd_busy(rd_busy), .seq_err(seq_err)
  );

  always_ff @(posedge clk) begin
    if (rst)                    rd_data <= 8'h00;
    else if (reg_addr == A_CTRL) rd_data <= ctrl_of(state);
    else if (reg_addr == A_STAT) rd_data <= {6'b0, rd_busy, seq_err};
    else                        rd_data <= 8'h00;
  end

  a_r7_byte_in_row: assert property (@(posedge clk) disable iff (rst)
    (arr_latch && arr_prog) |-> (arr_addr[AW-1:ROW_LG] == row_q));
  a_r2_reserved_zero: assert property (@(posedge clk) disable iff (rst)
    (rd_data & 8'hF2) == 8'h00 || $past(reg_addr) != A_CTRL);
endmodule

// File: tb/flash_seq_ctrl_tb.sv
module flash_seq_ctrl_tb;
  localparam int AW = 11, TNVS = 4, TPGS = 12, TPROG = 6, TNVH = 3;
  localparam int TME = 20, TNVH1 = 4, TRCV = 7;

  logic clk = 0, rst = 1, reg_wr = 0, fw_wr = 0, secure = 0;
  logic [1:0] reg_addr = 0;
  logic [7:0] reg_wdata = 0, rd_data, fw_data = 0, arr_data;
  logic [AW-1:0] fw_addr = 0, arr_addr;
  logic arr_latch, arr_hv, arr_prog, arr_erase, rd_busy, seq_err;
  int n_chk = 0, n_fail = 0;
  bit fin = 0;
  logic [AW+7:0] exp_q[$];

  always #5 clk = ~clk;

  flash_seq_ctrl #(.AW(AW), .T_NVS(TNVS), .T_PGS(TPGS), .T_PROG(TPROG),
    .T_NVH(TNVH), .T_ME(TME), .T_NVH1(TNVH1), .T_RCV(TRCV)) u_dut (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .rd_data(rd_data), .fw_wr(fw_wr), .fw_addr(fw_addr),
    .fw_data(fw_data), .secure(secure), .arr_latch(arr_latch),
    .arr_addr(arr_addr), .arr_data(arr_data), .arr_hv(arr_hv),
    .arr_prog(arr_prog), .arr_erase(arr_erase), .rd_busy(rd_busy),
    .seq_err(seq_err));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr_ctrl(input logic [7:0] d);
    @(negedge clk); reg_wr = 1; reg_addr = 0; reg_wdata = d;
    @(negedge clk); reg_wr = 0;
  endtask

  task automatic fw_write(input logic [AW-1:0] a, input logic [7:0] d, input bit expect_strobe);
    if (expect_strobe) exp_q.push_back({a, d});
    @(negedge clk); fw_wr = 1; fw_addr = a; fw_data = d;
    @(negedge clk); fw_wr = 0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] q);
    @(negedge clk); reg_addr = a;
    @(negedge clk); q = rd_data;
  endtask

  // scoreboard monitor: every array latch strobe must match the next expected item
  always @(negedge clk) begin
    if (!rst && arr_latch) begin
      if (exp_q.size() == 0)
        chk(0, "R12 unexpected latch strobe", {arr_addr, arr_data}, 0);
      else begin
        logic [AW+7:0] e;
        e = exp_q.pop_front();
        chk({arr_addr, arr_data} == e, "R5 latch strobe addr/data", {arr_addr, arr_data}, e);
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!fin) begin
      chk(0, "watchdog expired", 0, 1);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    logic [7:0] q;
    int n;
    repeat (3) @(negedge clk);
    rst = 0;
    // R1 reset state
    rd(0, q); chk(q == 8'h00, "R1 control after reset", q, 0);
    rd(1, q); chk(q == 8'h00, "R1 status after reset", q, 0);
    chk({arr_hv, arr_prog, arr_erase, arr_latch, rd_busy} == 0, "R1 strobes after reset",
        {arr_hv, arr_prog, arr_erase, arr_latch, rd_busy}, 0);
    // R11 security blocks program bit
    @(negedge clk); secure = 1;
    wr_ctrl(8'h01);
    rd(0, q); chk(q == 8'h00, "R11 program bit blocked by security", q, 0);
    rd(1, q); chk(q == 8'h00, "R11 no error for blocked bit", q, 0);
    @(negedge clk); secure = 0;
    // R3 both modes at once
    wr_ctrl(8'h05);
    rd(0, q); chk(q == 8'h00, "R3 both-mode write rejected", q, 0);
    rd(1, q); chk(q == 8'h01, "R3 error flag raised", q, 1);
    wr_ctrl(8'h00);
    rd(1, q); chk(q == 8'h00, "R12 zero write clears flag", q, 0);
    // R2 program arm readback, R4 HV before latch
    wr_ctrl(8'hF3);
    rd(0, q); chk(q == 8'h01, "R2 program bit0, reserved bits read 0", q, 1);
    wr_ctrl(8'h09);
    rd(0, q); chk(q == 8'h01, "R4 HV before latch rejected", q, 1);
    wr_ctrl(8'h04);
    rd(0, q); chk(q == 8'h01, "R3 erase while program rejected", q, 1);
    wr_ctrl(8'h00); wr_ctrl(8'h01);
    // R5 latch write
    fw_write(11'h0C5, 8'hA5, 1);
    wr_ctrl(8'h09);
    rd(0, q); chk(q == 8'h01, "R4 HV before TNVS rejected", q, 1);
    rd(1, q); chk(q == 8'h03, "R5 busy and error after early HV", q, 3);
    repeat (TNVS + 2) @(negedge clk);
    wr_ctrl(8'h09);
    rd(0, q); chk(q == 8'h09, "R4 HV accepted after TNVS", q, 9);
    chk(arr_hv == 1, "R4 arr_hv high", arr_hv, 1);
    wr_ctrl(8'h00);
    rd(0, q); chk(q == 8'h09, "R12 illegal zero write only clears", q, 9);
    rd(1, q); chk(q == 8'h02, "R12 flag cleared", q, 2);
    // R6 early byte
    fw_write(11'h0C6, 8'h11, 0);
    rd(1, q); chk(q == 8'h03, "R6 byte before TPGS rejected", q, 3);
    wr_ctrl(8'h00);
    repeat (TPGS + 2) @(negedge clk);
    fw_write(11'h0C7, 8'h3C, 1);
    n = 0;
    while (arr_prog && n < 100) begin n++; @(negedge clk); end
    chk(n == TPROG, "R6 program pulse width", n, TPROG);
    // R7 row checks
    fw_write(11'h100, 8'h22, 0);
    rd(1, q); chk(q == 8'h03, "R7 byte outside row rejected", q, 3);
    wr_ctrl(8'h00);
    fw_write(11'h0FF, 8'h5A, 1);
    fw_write(11'h0C0, 8'h77, 0);
    rd(1, q); chk(q == 8'h03, "R6 byte during running pulse rejected", q, 3);
    wr_ctrl(8'h00);
    repeat (TPROG + 2) @(negedge clk);
    // R8 exit
    wr_ctrl(8'h08);
    wr_ctrl(8'h00);
    rd(0, q); chk(q == 8'h08, "R8 HV clear before TNVH rejected", q, 8);
    repeat (TNVH + 2) @(negedge clk);
    wr_ctrl(8'h00);
    rd(0, q); chk(q == 8'h00, "R8 HV cleared after TNVH", q, 0);
    chk(arr_hv == 0, "R8 arr_hv low", arr_hv, 0);
    // R10 recovery
    rd(1, q); chk(q == 8'h02, "R10 busy during recovery", q, 2);
    wr_ctrl(8'h04);
    rd(0, q); chk(q == 8'h00, "R10 mode set during recovery rejected", q, 0);
    wr_ctrl(8'h00);
    repeat (TRCV + 2) @(negedge clk);
    rd(1, q); chk(q == 8'h00, "R10 busy drops after TRCV", q, 0);
    // R9 erase sequence
    wr_ctrl(8'h04);
    fw_write(11'h555, 8'h00, 1);
    repeat (TNVS + 2) @(negedge clk);
    wr_ctrl(8'h0C);
    chk(arr_erase == 1, "R9 erase pulse high", arr_erase, 1);
    wr_ctrl(8'h08);
    rd(0, q); chk(q == 8'h0C, "R9 erase clear before TME rejected", q, 8'h0C);
    wr_ctrl(8'h00);
    repeat (TME + 2) @(negedge clk);
    wr_ctrl(8'h08);
    rd(0, q); chk(q == 8'h08 && arr_erase == 0, "R9 erase cleared after TME", q, 8);
    repeat (TNVH1 + 2) @(negedge clk);
    wr_ctrl(8'h00);
    repeat (TRCV + 2) @(negedge clk);
    rd(1, q); chk(q == 8'h00, "R10 idle after erase recovery", q, 0);
    chk(exp_q.size() == 0, "R5 all expected strobes seen", exp_q.size(), 0);
    fin = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule